// File: doc/BRIEF.md
# Multi-configuration lookup-table logic cell

This block is one logic cell of a time-multiplexed programmable array. It keeps several complete configurations on chip at once. Each configuration holds a 4-input truth table, a choice of signal for each table input and a flag that picks the cell's output path. A context number is broadcast to every cell. Each cycle that number decides which stored configuration drives the cell, so the same gate and input routing can do different work from one cycle to the next.

The input choices are drawn from a small local set. This set holds the cell's own output flip-flop and a group of neighbouring signals. The output flip-flop is the only path by which a result survives from one context step into the next. A configuration write port loads any context while evaluation goes on in whichever context is selected. A parameter chooses how the selected configuration is read. In the registered variant, the configuration for the context broadcast in one cycle is fetched into a register and drives the cell in the following cycle, which takes the memory read out of the evaluation path. In the direct variant, the memory is read in the same cycle.

Top module: `mctx_lut_cell`

## Requirements
- R1: The LUT output equals truth-table bit `tt[{in3,in2,in1,in0}]`. The truth table sits in configuration word bits [15:0] and `inK` is the value that LUT input K receives.
- R2: LUT input K takes its value from a 3-bit select field in word bits [16+3K+2 : 16+3K]. Code 0 selects the cell's own output flip-flop. Code c, for c in 1..7, selects `cand_in[c-1]`.
- R3: The cell holds 4 independent configurations. The active one is chosen by `ctx_id`, and each context keeps its own contents across use of the others.
- R4: A configuration write to a context that is not the active one does not change the cell output in that cycle or in the next.
- R5: A write whose `cfg_ctx` equals the `ctx_id` presented in the same cycle takes effect in the next cycle, in both read variants, as long as `ctx_id` does not change.
- R6: In the registered variant (`PIPELINED`=1), the configuration in force is the one selected by `ctx_id` one cycle earlier. It holds steady while `ctx_id` is unchanged and no write occurs.
- R7: In the direct variant (`PIPELINED`=0), a change of `ctx_id` alters the configuration in force within the same cycle.
- R8: When word bit 28 (bypass) is 1, `cell_out` is the combinational LUT value. When it is 0, `cell_out` is the output flip-flop.
- R9: While `rst_n` is low, every stored configuration, the configuration register and the output flip-flop are 0, so `cell_out` is 0.
- R10: On every clock edge out of reset, the output flip-flop captures the LUT value of that cycle, whatever the bypass setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_id | input | $clog2(NUM_CTX) | Broadcast context number |
| cand_in | input | NUM_CAND-1 | Local candidate signals for select codes 1 and up |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctx | input | $clog2(NUM_CTX) | Context index that the write targets |
| cfg_word | input | 2^LUT_K + LUT_K*$clog2(NUM_CAND) + 1 | Configuration word: truth table, select fields, bypass bit |
| cell_out | output | 1 | Cell output |

## Verification
The bench builds two copies of the cell from the default shape: 4 contexts, 4 LUT inputs and 8 candidates. The copy `uut` uses the registered read and a second copy uses the direct read. Both copies get the same stimulus, so the one-cycle lag of the configuration register and the same-cycle switch of the direct read are compared against each other. Writes to the active context, writes to idle contexts, feedback through select code 0 and both bypass settings all come up in each read variant.

// File: rtl/mctx_pkg.sv
package mctx_pkg;
   // Layout helpers for the configuration word: truth table, then one
   // select field per LUT input, then the bypass flag.
   function automatic int sel_width(input int n_cand);
      return $clog2(n_cand);
   endfunction

   function automatic int tt_width(input int k);
      return 1 << k;
   endfunction

   function automatic int sel_lsb(input int k, input int idx, input int n_cand);
      return tt_width(k) + idx * sel_width(n_cand);
   endfunction

   function automatic int bypass_pos(input int k, input int n_cand);
      return tt_width(k) + k * sel_width(n_cand);
   endfunction

   function automatic int word_width(input int k, input int n_cand);
      return bypass_pos(k, n_cand) + 1;
   endfunction

   typedef enum logic {
      READ_DIRECT = 1'b0,
      READ_STAGED = 1'b1
   } cfg_read_e;
endpackage

// File: rtl/mctx_cfg_store.sv
module mctx_cfg_store #(
   parameter int NUM_CTX   = 4,
   parameter int WORD_W    = 29,
   parameter bit PIPELINED = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(NUM_CTX)-1:0] rd_ctx,
   input  logic                       wr_en,
   input  logic [$clog2(NUM_CTX)-1:0] wr_ctx,
   input  logic [WORD_W-1:0]          wr_word,
   output logic [WORD_W-1:0]          active_word
);
   localparam mctx_pkg::cfg_read_e MODE =
      PIPELINED ? mctx_pkg::READ_STAGED : mctx_pkg::READ_DIRECT;

   logic [WORD_W-1:0] ctx_mem [NUM_CTX];

   generate
      for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ctx_mem[c] <= '0;
            else if (wr_en && (wr_ctx == c[$clog2(NUM_CTX)-1:0]))
               ctx_mem[c] <= wr_word;
         end
      end

      if (MODE == mctx_pkg::READ_STAGED) begin : g_staged
         logic [WORD_W-1:0] stage_q;
         logic [WORD_W-1:0] stage_d;
         // A write aimed at the context being fetched is forwarded so the
         // staged copy never holds a stale word.
         always_comb begin
            if (wr_en && (wr_ctx == rd_ctx))
               stage_d = wr_word;
            else
               stage_d = ctx_mem[rd_ctx];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage_q <= '0;
            else
               stage_q <= stage_d;
         end
         assign active_word = stage_q;
      end else begin : g_direct
         assign active_word = ctx_mem[rd_ctx];
      end
   endgenerate
endmodule

// File: rtl/mctx_in_sel.sv
module mctx_in_sel #(
   parameter int LUT_K    = 4,
   parameter int NUM_CAND = 8
) (
   input  logic [LUT_K*$clog2(NUM_CAND)-1:0] sel_bus,
   input  logic                              fb_bit,
   input  logic [NUM_CAND-2:0]               cand_in,
   output logic [LUT_K-1:0]                  lut_in
);
   localparam int SEL_W = $clog2(NUM_CAND);

   logic [NUM_CAND-1:0] pool;
   assign pool = {cand_in, fb_bit};

   generate
      for (genvar k = 0; k < LUT_K; k++) begin : g_pin
         logic [SEL_W-1:0] code;
         assign code      = sel_bus[k*SEL_W +: SEL_W];
         assign lut_in[k] = pool[code];
      end
   endgenerate
endmodule

// File: rtl/mctx_lut_eval.sv
module mctx_lut_eval #(
   parameter int LUT_K = 4
) (
   input  logic [(1<<LUT_K)-1:0] truth,
   input  logic [LUT_K-1:0]      idx,
   output logic                  value
);
   assign value = truth[idx];
endmodule

// File: rtl/mctx_lut_cell.sv
module mctx_lut_cell #(
   parameter int NUM_CTX   = 4,
   parameter int LUT_K     = 4,
   parameter int NUM_CAND  = 8,
   parameter bit PIPELINED = 1'b1
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic [$clog2(NUM_CTX)-1:0]                     ctx_id,
   input  logic [NUM_CAND-2:0]                            cand_in,
   input  logic                                           cfg_we,
   input  logic [$clog2(NUM_CTX)-1:0]                     cfg_ctx,
   input  logic [mctx_pkg::word_width(LUT_K,NUM_CAND)-1:0] cfg_word,
   output logic                                           cell_out
);
   localparam int TT_W   = mctx_pkg::tt_width(LUT_K);
   localparam int SEL_W  = mctx_pkg::sel_width(NUM_CAND);
   localparam int SEL_LO = mctx_pkg::sel_lsb(LUT_K, 0, NUM_CAND);
   localparam int BYP    = mctx_pkg::bypass_pos(LUT_K, NUM_CAND);
   localparam int WORD_W = mctx_pkg::word_width(LUT_K, NUM_CAND);

   generate
      if (NUM_CTX < 2 || (NUM_CTX & (NUM_CTX - 1)) != 0) begin : g_bad_ctx
         $error("NUM_CTX must be a power of two, at least 2");
      end
      if (NUM_CAND < 2 || (NUM_CAND & (NUM_CAND - 1)) != 0) begin : g_bad_cand
         $error("NUM_CAND must be a power of two, at least 2");
      end
      if (LUT_K < 1 || LUT_K > 6) begin : g_bad_k
         $error("LUT_K must lie in 1..6");
      end
   endgenerate

   logic [WORD_W-1:0]      active_word;
   logic [LUT_K-1:0]       lut_in;
   logic                   lut_val;
   logic                   q_reg;

   mctx_cfg_store #(
      .NUM_CTX  (NUM_CTX),
      .WORD_W   (WORD_W),
      .PIPELINED(PIPELINED)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_ctx     (ctx_id),
      .wr_en      (cfg_we),
      .wr_ctx     (cfg_ctx),
      .wr_word    (cfg_word),
      .active_word(active_word)
   );

   mctx_in_sel #(
      .LUT_K   (LUT_K),
      .NUM_CAND(NUM_CAND)
   ) u_sel (
      .sel_bus(active_word[SEL_LO +: LUT_K*SEL_W]),
      .fb_bit (q_reg),
      .cand_in(cand_in),
      .lut_in (lut_in)
   );

   mctx_lut_eval #(
      .LUT_K(LUT_K)
   ) u_lut (
      .truth(active_word[TT_W-1:0]),
      .idx  (lut_in),
      .value(lut_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q_reg <= 1'b0;
      else
         q_reg <= lut_val;
   end

   assign cell_out = active_word[BYP] ? lut_val : q_reg;
endmodule

// File: rtl/mctx_lut_cell_chk.sv
module mctx_lut_cell_chk #(
   parameter int CTX_W     = 2,
   parameter int WORD_W    = 29,
   parameter bit PIPELINED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CTX_W-1:0]  ctx_id,
   input logic              cfg_we,
   input logic [CTX_W-1:0]  cfg_ctx,
   input logic [WORD_W-1:0] cfg_word,
   input logic [WORD_W-1:0] active_word,
   input logic              lut_val,
   input logic              q_reg,
   input logic              cell_out
);
   assert_reset_clear_R9: assert property (@(posedge clk)
      !rst_n |-> (q_reg == 1'b0 && cell_out == 1'b0));

   assert_flop_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> q_reg == $past(lut_val));

   assert_active_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_ctx == ctx_id) |=>
         (active_word == $past(cfg_word) ||
          (PIPELINED == 1'b0 && ctx_id != $past(ctx_id))));

   assert_staged_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (PIPELINED == 1'b1 && !cfg_we && ctx_id == $past(ctx_id)) |=>
         $stable(active_word));
endmodule

bind mctx_lut_cell mctx_lut_cell_chk #(
   .CTX_W    ($clog2(NUM_CTX)),
   .WORD_W   (WORD_W),
   .PIPELINED(PIPELINED)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctx_id     (ctx_id),
   .cfg_we     (cfg_we),
   .cfg_ctx    (cfg_ctx),
   .cfg_word   (cfg_word),
   .active_word(active_word),
   .lut_val    (lut_val),
   .q_reg      (q_reg),
   .cell_out   (cell_out)
);

// File: tb/mctx_lut_cell_test.sv
module mctx_lut_cell_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  ctx_id = '0;
   logic [6:0]  cand_in = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_ctx = '0;
   logic [28:0] cfg_word = '0;
   logic        out_stg;
   logic        out_dir;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   mctx_lut_cell #(.NUM_CTX(4), .LUT_K(4), .NUM_CAND(8), .PIPELINED(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .ctx_id(ctx_id), .cand_in(cand_in),
      .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_word(cfg_word), .cell_out(out_stg));

   mctx_lut_cell #(.NUM_CTX(4), .LUT_K(4), .NUM_CAND(8), .PIPELINED(1'b0)) uut_dir (
      .clk(clk), .rst_n(rst_n), .ctx_id(ctx_id), .cand_in(cand_in),
      .cfg_we(cfg_we), .cfg_ctx(cfg_ctx), .cfg_word(cfg_word), .cell_out(out_dir));

   // Reference state
   logic [28:0] m_mem [4];
   logic [28:0] m_stage;
   logic        m_q_stg;
   logic        m_q_dir;

   function automatic logic [28:0] mk(input logic [15:0] tt, input int s0, input int s1,
                                      input int s2, input int s3, input logic byp);
      logic [2:0] a = s0[2:0];
      logic [2:0] b = s1[2:0];
      logic [2:0] c = s2[2:0];
      logic [2:0] d = s3[2:0];
      return {byp, d, c, b, a, tt};
   endfunction

   function automatic logic lut_of(input logic [28:0] w, input logic q, input logic [6:0] cand);
      logic [3:0] idx;
      for (int k = 0; k < 4; k++) begin
         int code = int'(w[16 + 3*k +: 3]);
         idx[k] = (code == 0) ? q : cand[code - 1];
      end
      return w[idx];
   endfunction

   task automatic cmp(input string tag, input string which, input logic got, input logic exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %b expected %b at %0t", tag, which, got, exp, $time);
      end
   endtask

   // Compare both copies against the model, then advance the model one edge.
   task automatic step(input string tag);
      logic [28:0] w_s, w_d;
      logic v_s, v_d;
      #1;
      w_s = m_stage;
      w_d = m_mem[ctx_id];
      v_s = lut_of(w_s, m_q_stg, cand_in);
      v_d = lut_of(w_d, m_q_dir, cand_in);
      cmp(tag, "staged", out_stg, w_s[28] ? v_s : m_q_stg);
      cmp(tag, "direct", out_dir, w_d[28] ? v_d : m_q_dir);
      m_q_stg = v_s;
      m_q_dir = v_d;
      m_stage = (cfg_we && cfg_ctx == ctx_id) ? cfg_word : m_mem[ctx_id];
      if (cfg_we) m_mem[cfg_ctx] = cfg_word;
      @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [1:0] c, input logic [28:0] w, input string tag);
      cfg_we = 1'b1; cfg_ctx = c; cfg_word = w;
      step(tag);
      cfg_we = 1'b0;
   endtask

   initial begin
      #2000000;
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) m_mem[i] = '0;
      m_stage = '0; m_q_stg = 1'b0; m_q_dir = 1'b0;
      rst_n = 1'b1;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R9: outputs are 0 while held in reset
      #1;
      cmp("R9", "staged", out_stg, 1'b0);
      cmp("R9", "direct", out_dir, 1'b0);
      rst_n = 1'b1;
      step("R9");
      step("R9");

      // R4: load idle contexts while context 0 runs
      cand_in = 7'b0001111;
      wr(2'd1, mk(16'h8000, 1, 2, 3, 4, 1'b1), "R4");   // 4-input AND, bypass
      step("R4");
      wr(2'd2, mk(16'h6996, 5, 6, 7, 1, 1'b0), "R4");   // parity, registered
      wr(2'd3, mk(16'h6666, 0, 1, 1, 1, 1'b0), "R4");   // toggle on cand_in[0]
      step("R4");

      // R1 / R8 / R6 / R7: AND in context 1
      ctx_id = 2'd1;
      step("R7"); step("R6"); step("R1");
      cand_in = 7'b0000111;
      step("R8"); step("R1");

      // Parity, registered output
      ctx_id = 2'd2;
      for (int i = 0; i < 8; i++) begin
         cand_in = 7'(i * 37);
         step("R1");
      end

      // R2 / R10: feedback toggle through select code 0
      ctx_id = 2'd3;
      cand_in = 7'b0000001;
      for (int i = 0; i < 6; i++) step("R10");
      cand_in = 7'b0000000;
      step("R2"); step("R2");

      // R5: rewrite the active context
      wr(2'd3, mk(16'hFFFF, 1, 2, 3, 4, 1'b1), "R5");
      step("R5"); step("R5");
      wr(2'd3, mk(16'h0000, 1, 2, 3, 4, 1'b1), "R5");
      step("R5");

      // R3: contexts keep their contents while cycling
      for (int r = 0; r < 3; r++) begin
         for (int c = 0; c < 4; c++) begin
            ctx_id = 2'(c);
            cand_in = 7'(c * 29 + r);
            step("R3");
         end
      end

      // Mixed traffic: random contexts, inputs and background writes
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r = $urandom();
         logic [31:0] r2 = $urandom();
         ctx_id  = r[1:0];
         cand_in = r[8:2];
         cfg_we  = (r[12:9] < 4'd4);
         cfg_ctx = r[14:13];
         if (r[15]) cfg_ctx = ctx_id;
         cfg_word = r2[28:0];
         step(cfg_we && cfg_ctx == ctx_id ? "R5" : "R3");
      end
      cfg_we = 1'b0;
      step("R3");

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule